// File: doc/BRIEF.md
# JTAG chain integrity byte checker

This block is the host side of a JTAG scan engine. It drives TCK, TMS and TDI and samples TDO. For each instruction-register (IR) or data-register (DR) scan, it walks the target TAP controllers from Run-Test/Idle through capture and shift and back to idle. It also sends a fixed 8-bit marker ahead of the payload. When the marker returns unchanged after exactly the expected chain length, the chain is proven to be in step with the host. If one bit of it differs, the scan is flagged as a chain failure.

Software picks the scan type and gives the IR and DR chain lengths. The DR length changes with the data register that the last instruction selected: after a target reset this is the identification register, or the one-bit bypass register on devices that have no identification register. Software also supplies the payload and may switch the marker off. When the scan ends, the block holds the captured bits, the eight returned marker bits and the pass/fail result. After a failed DR scan, it runs an IR scan by itself to help locate the fault, and it reports that result separately.

Top module: `jtag_chain_checker`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and diag_fail_o are low, rx_data_o and marker_rx_o are zero, and tck_o stays low whenever the block is idle.
- R2: A DR scan drives TMS 1,0,0 from Run-Test/Idle to reach Shift-DR. An IR scan drives 1,1,0,0 to reach Shift-IR. TMS is high only on the final shifted bit and is then 1,0, so the targets pass through Exit1 and Update and return to Run-Test/Idle.
- R3: With the marker enabled, the shift is chain length plus 8 bits. The first 8 TDI bits are the marker 0x52 sent LSB first, and payload bit i follows as TDI bit i+8.
- R4: TMS and TDI change only on the clock edge where TCK falls, and they hold steady while TCK is high. TDO is sampled on the edge where TCK rises.
- R5: marker_rx_o bit j is the TDO bit captured at shift position chain length + j. fail_o is set when the marker is enabled and this byte differs from 0x52 in any bit.
- R6: rx_data_o bit i is the TDO bit captured at shift position i, for i below the chain length. Higher bits read zero.
- R7: With the marker disabled, exactly the chain length is shifted, TDI bit i is payload bit i, no check is made, fail_o stays low and marker_rx_o reads zero, whatever TDO returns.
- R8: After a DR scan fails, the block runs one IR scan of ir_len_i bits with an all-ones payload and the marker. diag_fail_o reports whether that scan's marker failed. busy_o stays high through both scans.
- R9: A failed IR scan starts no further scan, and diag_fail_o stays low.
- R10: An IR scan uses ir_len_i as its chain length and a DR scan uses dr_len_i, both in the range 1 to MAX_LEN.
- R11: done_o pulses high for one cycle as busy_o falls. The status outputs hold until the next accepted start, which clears them. A start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan (accepted only when idle) |
| scan_ir_i | input | 1 | 1: IR scan, 0: DR scan |
| marker_en_i | input | 1 | Append and check the marker byte |
| ir_len_i | input | $clog2(MAX_LEN+1) | IR chain length in bits |
| dr_len_i | input | $clog2(MAX_LEN+1) | DR chain length in bits for the selected register |
| tx_data_i | input | MAX_LEN | Payload, bit 0 shifted first |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Serial data to the chain |
| tdo_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Scan (and any diagnostic scan) in progress |
| done_o | output | 1 | One-cycle pulse at the end of the operation |
| fail_o | output | 1 | Marker check of the requested scan failed |
| diag_fail_o | output | 1 | Marker check of the automatic IR scan failed |
| marker_rx_o | output | 8 | Marker byte as returned by the chain |
| rx_data_o | output | MAX_LEN | Captured chain bits of the requested scan |

## Verification
A TAP-state model of the target chain is driven by the block's own pins, and its register lengths can be set apart from the lengths the host assumes. Matched lengths on both IR and DR, including the one-bit bypass case and the full width, show that the marker is placed and recovered correctly. Chains one bit longer or two bits shorter than expected show that a slipped marker is caught and that the diagnostic IR scan follows a DR failure but not an IR failure. Scans with the marker disabled and a wrong length show that no check is made. TDO held low or held high shows that all-zero and all-one failures are detected. The model's shift-edge and Update-IR counts and its final state confirm the TMS walk and the number of bits shifted.

// File: rtl/jcc_pkg.sv
package jcc_pkg;
  localparam int          MARK_W = 8;
  localparam logic [7:0]  MARK   = 8'h52;
  localparam int          PRE_DR = 3;  // 1,0,0 : idle -> shift-dr
  localparam int          PRE_IR = 4;  // 1,1,0,0 : idle -> shift-ir
  localparam int          POST_N = 2;  // exit1 -> update -> idle

  typedef enum logic [1:0] {ST_IDLE, ST_MAIN, ST_DIAG} jcc_st_e;
endpackage

// File: rtl/jcc_tck_gen.sv
module jcc_tck_gen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNTW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNTW-1:0] cnt_q;
  logic            tck_q;
  logic            wrap;

  assign wrap = (cnt_q == CNTW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = run_i && wrap && !tck_q;
  assign fall_o = run_i && wrap && tck_q;
endmodule

// File: rtl/jcc_seq.sv
module jcc_seq import jcc_pkg::*; #(
  parameter int MAX_LEN = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               load_i,
  input  logic                               fall_i,
  input  logic                               ir_i,
  input  logic                               men_i,
  input  logic [$clog2(MAX_LEN+1)-1:0]       len_i,
  input  logic [MAX_LEN+MARK_W-1:0]          tx_i,
  output logic                               tms_o,
  output logic                               tdi_o,
  output logic                               shift_o,
  output logic [$clog2(MAX_LEN+MARK_W+1)-1:0] sidx_o,
  output logic                               done_o
);
  localparam int TXW = MAX_LEN + MARK_W;
  localparam int KW  = $clog2(TXW + 1);
  localparam int CW  = $clog2(TXW + PRE_IR + POST_N + 1);

  logic [CW-1:0] c_q, pre_n, nbits, sh_end, last_c;
  logic [KW-1:0] k;
  logic          in_sh;

  assign pre_n  = ir_i ? CW'(PRE_IR) : CW'(PRE_DR);
  assign nbits  = CW'(len_i) + (men_i ? CW'(MARK_W) : CW'(0));
  assign sh_end = pre_n + nbits;
  assign last_c = sh_end + CW'(POST_N - 1);
  assign in_sh  = (c_q >= pre_n) && (c_q < sh_end);
  assign k      = KW'(c_q - pre_n);

  always_comb begin
    tdi_o = 1'b0;
    if (c_q < pre_n) begin
      tms_o = (c_q == '0) || (ir_i && c_q == CW'(1));
    end else if (in_sh) begin
      tms_o = (c_q == sh_end - CW'(1));  // leave shift on last bit
      tdi_o = tx_i[k];
    end else begin
      tms_o = (c_q == sh_end);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       c_q <= '0;
    else if (load_i)                   c_q <= '0;
    else if (fall_i && c_q != last_c)  c_q <= c_q + CW'(1);
  end

  assign shift_o = in_sh;
  assign sidx_o  = k;
  assign done_o  = fall_i && (c_q == last_c);
endmodule

// File: rtl/jtag_chain_checker.sv
module jtag_chain_checker import jcc_pkg::*; #(
  parameter int MAX_LEN = 32,
  parameter int HALF    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         scan_ir_i,
  input  logic                         marker_en_i,
  input  logic [$clog2(MAX_LEN+1)-1:0] ir_len_i,
  input  logic [$clog2(MAX_LEN+1)-1:0] dr_len_i,
  input  logic [MAX_LEN-1:0]           tx_data_i,
  output logic                         tck_o,
  output logic                         tms_o,
  output logic                         tdi_o,
  input  logic                         tdo_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         fail_o,
  output logic                         diag_fail_o,
  output logic [7:0]                   marker_rx_o,
  output logic [MAX_LEN-1:0]           rx_data_o
);
  localparam int TXW = MAX_LEN + MARK_W;
  localparam int LW  = $clog2(MAX_LEN + 1);
  localparam int KW  = $clog2(TXW + 1);

  jcc_st_e            st_q;
  logic               ir_q, men_q;
  logic [LW-1:0]      len_q;
  logic [TXW-1:0]     tx_q, rx_q;
  logic [MAX_LEN-1:0] rxd_q, lmask;
  logic [7:0]         mrx_q, mk_now;
  logic               fail_q, dfail_q, done_q;
  logic               run, rise, fall, in_sh, seq_done;
  logic               accept, go_diag, load, mk_bad;
  logic [KW-1:0]      sidx;

  assign run     = (st_q != ST_IDLE);
  assign accept  = start_i && !run;
  assign mk_now  = rx_q[len_q +: MARK_W];
  assign mk_bad  = men_q && (mk_now != MARK);
  assign go_diag = seq_done && (st_q == ST_MAIN) && mk_bad && !ir_q;
  assign load    = accept || go_diag;

  always_comb begin
    for (int i = 0; i < MAX_LEN; i++) lmask[i] = (i < int'(len_q));
  end

  jcc_tck_gen #(.HALF(HALF)) i_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  jcc_seq #(.MAX_LEN(MAX_LEN)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .fall_i  (fall),
    .ir_i    (ir_q),
    .men_i   (men_q),
    .len_i   (len_q),
    .tx_i    (tx_q),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o),
    .shift_o (in_sh),
    .sidx_o  (sidx),
    .done_o  (seq_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ir_q    <= 1'b0;
      men_q   <= 1'b0;
      len_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rxd_q   <= '0;
      mrx_q   <= '0;
      fail_q  <= 1'b0;
      dfail_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q    <= ST_MAIN;
        ir_q    <= scan_ir_i;
        len_q   <= scan_ir_i ? ir_len_i : dr_len_i;
        men_q   <= marker_en_i;
        tx_q    <= marker_en_i ? {tx_data_i, MARK} : {MARK_W'(0), tx_data_i};
        rx_q    <= '0;
        rxd_q   <= '0;
        mrx_q   <= '0;
        fail_q  <= 1'b0;
        dfail_q <= 1'b0;
      end else if (run) begin
        if (rise && in_sh) rx_q[sidx] <= tdo_i;
        if (seq_done) begin
          if (st_q == ST_MAIN) begin
            rxd_q  <= rx_q[MAX_LEN-1:0] & lmask;
            mrx_q  <= mk_now;
            fail_q <= mk_bad;
            if (go_diag) begin
              // follow-up IR scan: all ones with marker
              st_q  <= ST_DIAG;
              ir_q  <= 1'b1;
              len_q <= ir_len_i;
              men_q <= 1'b1;
              tx_q  <= {{MAX_LEN{1'b1}}, MARK};
              rx_q  <= '0;
            end else begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            dfail_q <= mk_bad;
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o      = run;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign diag_fail_o = dfail_q;
  assign marker_rx_o = mrx_q;
  assign rx_data_o   = rxd_q;
endmodule

// File: rtl/jcc_checker.sv
module jcc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic tck_o,
  input logic tms_o,
  input logic tdi_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o,
  input logic diag_fail_o
);
  // R4
  pins_steady_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  // R1
  idle_tck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tck_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  diag_needs_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_fail_o |-> fail_o);

  // R11
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(diag_fail_o)));
endmodule

bind jtag_chain_checker jcc_checker i_jcc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .tck_o       (tck_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .diag_fail_o (diag_fail_o)
);

// File: tb/test_jtag_chain_checker.sv
`timescale 1ns/1ps
module test_jtag_chain_checker;
  localparam int ML  = 32;
  localparam int LW  = $clog2(ML + 1);
  localparam int IRL = 6;
  localparam logic [63:0] IR_CAP = 64'h5555_5555_5555_5555;
  localparam logic [63:0] DR_CAP = 64'h0F1E_2D3C_A5C3_1E0F;
  localparam logic [7:0]  MK     = 8'h52;
  localparam int NV = 8;
  // {ir, marker_en, host_len, target_len, payload}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'd32, 6'd32, 32'h1234_5678},
    {1'b1, 1'b1, 6'd6,  6'd6,  32'h0000_003F},
    {1'b0, 1'b1, 6'd1,  6'd1,  32'h0000_0000},
    {1'b0, 1'b1, 6'd8,  6'd9,  32'h0000_00C3},
    {1'b0, 1'b1, 6'd12, 6'd10, 32'h0000_0A5A},
    {1'b0, 1'b0, 6'd16, 6'd16, 32'h0000_BEEF},
    {1'b0, 1'b0, 6'd16, 6'd20, 32'h0000_1357},
    {1'b1, 1'b1, 6'd6,  6'd7,  32'h0000_0015}
  };

  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIR, CIR, SHI, E1I, PIR, E2I, UIR} tap_e;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, scan_ir = 1'b0, men = 1'b0;
  logic [LW-1:0] ir_len = LW'(IRL), dr_len = '0;
  logic [ML-1:0] txd = '0;
  logic tck, tms, tdi, tdo, busy, done, fail, dfail;
  logic [7:0] mrx;
  logic [ML-1:0] rxd;

  int n_chk = 0, n_fail = 0;
  int tgt_ir = IRL, tgt_dr = 32;
  int nsh = 0, nuir = 0;
  logic stuck_en = 1'b0, stuck_val = 1'b0;
  tap_e ts = RTI;
  logic [63:0] sr = '0;
  logic tdo_q = 1'b0;

  always #2.5 clk = ~clk;

  jtag_chain_checker #(.MAX_LEN(ML), .HALF(2)) i_jtag_chain_checker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scan_ir_i(scan_ir),
    .marker_en_i(men), .ir_len_i(ir_len), .dr_len_i(dr_len), .tx_data_i(txd),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo), .busy_o(busy),
    .done_o(done), .fail_o(fail), .diag_fail_o(dfail),
    .marker_rx_o(mrx), .rx_data_o(rxd)
  );

  // ---- target chain model ----
  function automatic tap_e tap_nxt(tap_e s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    case (ts)
      CDR: sr = DR_CAP;
      CIR: sr = IR_CAP;
      SHD: begin sr = sr >> 1; sr[tgt_dr-1] = tdi; nsh++; end
      SHI: begin sr = sr >> 1; sr[tgt_ir-1] = tdi; nsh++; end
      UIR: nuir++;
      default: ;
    endcase
    ts = tap_nxt(ts, tms);
  end
  always @(negedge tck) tdo_q = sr[0];
  assign tdo = stuck_en ? stuck_val : tdo_q;

  // ---- helpers ----
  function automatic logic exp_bit(int k, int tl, logic [63:0] cap, logic [39:0] tx);
    if (k < tl) return cap[k];
    return tx[k - tl];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_scan(logic ir, logic me, int hl, logic [ML-1:0] d);
    @(negedge clk);
    scan_ir = ir; men = me; txd = d;
    if (ir) ir_len = LW'(hl); else dr_len = LW'(hl);
    nsh = 0; nuir = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 5000 && !done; w++) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 done never seen act=0 exp=1");
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 status", {fail, dfail, done, tck, mrx}, 0);
    chk("R1 rx", 64'(rxd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle tck", 64'(tck), 0);

    // table walk: R2 R3 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic vir, vme; int hl, tl; logic [31:0] vd;
      logic [39:0] tx; logic [63:0] cap;
      logic [ML-1:0] erx; logic [7:0] emk, edm; logic ef, ed;
      vir = VEC[v][45]; vme = VEC[v][44];
      hl = int'(VEC[v][43:38]); tl = int'(VEC[v][37:32]); vd = VEC[v][31:0];
      tx  = vme ? {vd, MK} : {8'h00, vd};
      cap = vir ? IR_CAP : DR_CAP;
      if (vir) begin tgt_ir = tl; ir_len = LW'(hl); end
      else begin tgt_ir = IRL; ir_len = LW'(IRL); tgt_dr = tl; end
      erx = '0; emk = '0; edm = '0;
      for (int i = 0; i < hl; i++) erx[i] = exp_bit(i, tl, cap, tx);
      if (vme) for (int j = 0; j < 8; j++) emk[j] = exp_bit(hl + j, tl, cap, tx);
      ef = vme && (emk != MK);
      for (int j = 0; j < 8; j++)
        edm[j] = exp_bit(IRL + j, tgt_ir, IR_CAP, {32'hFFFF_FFFF, MK});
      ed = ef && !vir && (edm != MK);
      do_scan(vir, vme, hl, vd);
      chk("R6 rx_data", 64'(rxd), 64'(erx));
      chk("R5 marker_rx", 64'(mrx), 64'(emk));
      chk("R5 R7 fail", 64'(fail), 64'(ef));
      chk("R8 R9 diag_fail", 64'(dfail), 64'(ed));
      chk("R2 R10 shifted bits", 64'(nsh),
          64'(hl + (vme ? 8 : 0) + ((ef && !vir) ? IRL + 8 : 0)));
      chk("R8 R9 ir updates", 64'(nuir), 64'((vir ? 1 : 0) + ((ef && !vir) ? 1 : 0)));
      chk("R2 back in idle", 64'(ts), 64'(RTI));
    end

    // R5 R8: TDO stuck low on a DR scan, diag also fails
    tgt_dr = 8; tgt_ir = IRL; ir_len = LW'(IRL);
    stuck_en = 1'b1; stuck_val = 1'b0;
    do_scan(1'b0, 1'b1, 8, 32'h0000_00FF);
    chk("R5 stuck0 marker", 64'(mrx), 64'h00);
    chk("R5 stuck0 fail", 64'(fail), 1);
    chk("R8 stuck0 diag", 64'(dfail), 1);
    chk("R8 diag ir scan ran", 64'(nuir), 1);

    // R11: status held while idle
    repeat (30) @(negedge clk);
    chk("R11 hold fail", {fail, dfail, mrx}, {1'b1, 1'b1, 8'h00});

    // R9: TDO stuck high on an IR scan, no follow-up
    stuck_val = 1'b1;
    do_scan(1'b1, 1'b1, IRL, 32'h0);
    chk("R5 stuck1 marker", 64'(mrx), 64'hFF);
    chk("R9 stuck1 fail", 64'(fail), 1);
    chk("R9 no diag", 64'(dfail), 0);
    chk("R9 one ir update", 64'(nuir), 1);
    chk("R9 shifted bits", 64'(nsh), 64'(IRL + 8));
    stuck_en = 1'b0;

    // R11: start clears status; start while busy ignored
    tgt_dr = 8;
    @(negedge clk);
    scan_ir = 1'b0; men = 1'b1; dr_len = LW'(8); txd = 32'h0000_0033;
    nsh = 0; nuir = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 start clears", {busy, fail, dfail, mrx}, {1'b1, 1'b0, 1'b0, 8'h00});
    repeat (10) @(negedge clk);
    scan_ir = 1'b1; dr_len = LW'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 5000 && !done; w++) @(negedge clk);
    chk("R11 busy start ignored fail", 64'(fail), 0);
    chk("R11 busy start ignored bits", 64'(nsh), 16);
    chk("R11 busy start ignored marker", 64'(mrx), 64'(MK));
    @(negedge clk);
    chk("R11 done one cycle", 64'(done), 0);
    repeat (40) @(negedge clk);
    chk("R11 stays idle", {busy, tck}, 0);

    finish_run();
  end
endmodule